// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control around an analog-to-digital converter core. A CPU programs a control register that holds an interrupt enable, a continuous-run bit and a five-bit channel code. A read-only done flag sits in the same register. A separate divider register sets how much slower than the bus clock the converter clock runs. A write to the control register starts a conversion. The conversion is aligned to the next converter-clock tick and lasts sixteen ticks. On its last cycle the sequencer captures the 8-bit result presented by the core.

Completion is reported in one of two ways. With interrupts disabled, a sticky done flag is set. With interrupts enabled, a level interrupt request is raised and the done flag stays clear. Reading the result or writing the control register clears whichever indicator is set. The all-ones channel code parks the converter. A stop input aborts any work in progress. After stop is released, the sequencer waits one full conversion period for the analog side to settle before it starts any conversion.

Top module: `adc_sequencer`

## Requirements
- R1: From the clock edge that registers a control write, the end-of-conversion edge comes after 16 converter periods plus an alignment wait of one to one full period. In bus cycles this is between 16·P+1 and 17·P, where P is the converter period.
- R2: In single mode (continuous bit 0), each control write yields exactly one conversion. `busy` is high while it runs and low afterwards.
- R3: With the continuous bit (bit 5) set, conversions follow back to back. Each one overwrites `result` whether or not it was read. The run ends when a control write clears the bit or parks the converter.
- R4: With the interrupt enable (bit 6) clear, status bit 7 (done) sets at the end of a conversion. It holds until a `rd_data` pulse or a control write.
- R5: With the interrupt enable set, `irq` rises at the end of every conversion and holds as a level until a `rd_data` pulse or a control write. Done stays 0 while the enable is set.
- R6: A channel code of 31 in bits 4:0 parks the converter. No conversion starts and `busy` stays low.
- R7: The converter period is P = 2·(D+1) bus cycles, where D is bits 2:0 of a `wr_div` write. D resets to 0.
- R8: While `stop` is high, any pending or running conversion is aborted. No `eoc` occurs and `result` keeps its value.
- R9: After `stop` falls, 16 converter periods of settling pass before a conversion may start. A continuous run then resumes by itself, with its end-of-conversion edge between 32·P+1 and 33·P bus cycles after the release edge. A single-mode conversion needs a control write.
- R10: A control write during a conversion aborts it without changing `result` and restarts the timing from that write.
- R11: `status` reads {done, enable, continuous, channel[4:0]}. After reset, `status`, `result`, `irq`, `busy` and `eoc` are all 0.
- R12: `eoc` pulses for exactly one cycle, in the cycle after `result` is loaded from `core_result`, and only at the end of a conversion that ran.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_ctl | input | 1 | Control register write strobe |
| wr_div | input | 1 | Divider register write strobe |
| wdata | input | 8 | Write data |
| rd_data | input | 1 | Result register read strobe |
| stop | input | 1 | Abort and halt |
| core_result | input | 8 | Converted value from the converter core |
| status | output | 8 | Control/status register value |
| result | output | 8 | Result register |
| chan_sel | output | 5 | Channel code to the core |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion pulse |
| irq | output | 1 | Interrupt request level |

## Verification
The bench measures start latency against the 16-to-17 period window at two divider settings. A design that ignored write-to-tick alignment, or that miscounted the divider, lands outside that window. It runs a continuous sequence without reads and changes the core value between conversions. A sequencer that skipped overwrites or stopped after one result would hand the scoreboard a stale value. Stop is applied both in single and in continuous mode, and a control write is issued mid-conversion. A design that let aborted work reach `result`, resumed without settling, or restarted single conversions on its own raises an unexpected end-of-conversion or misses the resume window. Flag tests confirm that the done flag stays low under interrupt mode and that a read or a write clears each indicator.

// File: rtl/adc_sequencer.sv
module adc_sequencer #(
  parameter int DATA_W     = 8,
  parameter int CH_W       = 5,
  parameter int DIV_W      = 3,
  parameter int CONV_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_div,
  input  logic [CH_W+2:0]   wdata,
  input  logic              rd_data,
  input  logic              stop,
  input  logic [DATA_W-1:0] core_result,
  output logic [CH_W+2:0]   status,
  output logic [DATA_W-1:0] result,
  output logic [CH_W-1:0]   chan_sel,
  output logic              busy,
  output logic              eoc,
  output logic              irq
);
  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CONV, S_STOP, S_SETTLE} st_t;

  st_t              st_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ien_q, cont_q, done_q, irq_q, eoc_q, pend_q;
  logic [CH_W-1:0]  chan_q;
  logic [DATA_W-1:0] data_q;
  logic             tick, finish, park, w_park;

  assign tick   = (pre_q == {div_q, 1'b1});
  assign park   = &chan_q;
  assign w_park = &wdata[CH_W-1:0];
  assign finish = (st_q == S_CONV) && tick && (cnt_q == LAST) && !stop && !wr_ctl;

  assign status   = {done_q, ien_q, cont_q, chan_q};
  assign result   = data_q;
  assign chan_sel = chan_q;
  assign busy     = (st_q == S_CONV);
  assign eoc      = eoc_q;
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (wr_div) begin
      div_q <= wdata[DIV_W-1:0];
      pre_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      cont_q <= 1'b0;
      chan_q <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      eoc_q  <= 1'b0;
      data_q <= '0;
    end else begin
      eoc_q <= finish;
      if (finish) data_q <= core_result;
      if (wr_ctl) begin
        ien_q  <= wdata[CH_W+1];
        cont_q <= wdata[CH_W];
        chan_q <= wdata[CH_W-1:0];
      end
      if (finish && !ien_q)      done_q <= 1'b1;
      else if (wr_ctl || rd_data) done_q <= 1'b0;
      if (finish && ien_q)       irq_q <= 1'b1;
      else if (wr_ctl || rd_data) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (stop) begin
      st_q <= S_STOP;
      if (wr_ctl) pend_q <= !w_park;
      else if (st_q != S_STOP) pend_q <= 1'b0;
    end else begin
      case (st_q)
        S_STOP: begin
          st_q  <= S_SETTLE;
          cnt_q <= '0;
          if (wr_ctl) pend_q <= !w_park;
        end
        S_SETTLE: begin
          if (wr_ctl) pend_q <= !w_park;
          if (tick) begin
            if (cnt_q == LAST) begin
              st_q   <= ((pend_q || cont_q) && !park) ? S_WAIT : S_IDLE;
              pend_q <= 1'b0;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_WAIT: if (tick) begin
          st_q  <= park ? S_IDLE : S_CONV;
          cnt_q <= '0;
        end
        S_CONV: if (tick) begin
          if (cnt_q == LAST) begin
            st_q  <= cont_q ? S_CONV : S_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
      if (wr_ctl && st_q != S_STOP && st_q != S_SETTLE)
        st_q <= w_park ? S_IDLE : S_WAIT;
    end
  end
endmodule

module adc_sequencer_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_ctl,
  input logic            rd_data,
  input logic            stop,
  input logic [CH_W+2:0] status,
  input logic            busy,
  input logic            eoc,
  input logic            irq
);
  a_r5_no_done_with_irq_en: assert property (@(posedge clk) disable iff (!rst_n)
    status[CH_W+1] |-> !status[CH_W+2]);

  a_r5_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data || wr_ctl) && !eoc) |-> !irq);

  a_r6_parked_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (&status[CH_W-1:0]) |-> !busy);

  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !eoc));

  a_r12_eoc_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(busy));

  a_r12_eoc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
endmodule

bind adc_sequencer adc_sequencer_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .rd_data(rd_data), .stop(stop),
  .status(status), .busy(busy), .eoc(eoc), .irq(irq)
);

// File: tb/adc_sequencer_bench.sv
`timescale 1ns/1ps
module adc_sequencer_bench;
  logic       clk = 0, rst_n = 0;
  logic       wr_ctl = 0, wr_div = 0, rd_data = 0, stop = 0;
  logic [7:0] wdata = 0, core_result = 0;
  logic [7:0] status, result;
  logic [4:0] chan_sel;
  logic       busy, eoc, irq;

  int total = 0, bad = 0, cyc = 0, eoc_n = 0, eoc_cyc = 0, wcyc = 0;
  logic [7:0] exp_q[$];
  bit finished = 0;

  adc_sequencer u_adc_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_div(wr_div), .wdata(wdata),
    .rd_data(rd_data), .stop(stop), .core_result(core_result), .status(status),
    .result(result), .chan_sel(chan_sel), .busy(busy), .eoc(eoc), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input int v, input int lo, input int hi);
    total++;
    if (v < lo || v > hi) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, v, lo, hi);
    end
  endtask

  // monitor: every end of conversion is scored against the queue
  always @(negedge clk) if (rst_n && eoc) begin
    eoc_n++;
    eoc_cyc = cyc;
    if (exp_q.size() == 0) check(0, "R12", "unexpected eoc", result, -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(result == e, "R12", "scoreboard result", result, e);
    end
  end

  task automatic do_wr(input logic ien, input logic cont, input logic [4:0] ch);
    @(negedge clk);
    wdata = {1'b0, ien, cont, ch};
    wr_ctl = 1;
    wcyc = cyc;
    @(negedge clk);
    wr_ctl = 0;
  endtask

  task automatic do_div(input logic [2:0] d);
    @(negedge clk);
    wdata = {5'd0, d};
    wr_div = 1;
    @(negedge clk);
    wr_div = 0;
  endtask

  task automatic do_rd();
    @(negedge clk);
    rd_data = 1;
    @(negedge clk);
    rd_data = 0;
  endtask

  task automatic wait_eoc(input string req);
    int start, k;
    start = eoc_n;
    k = 0;
    while (eoc_n == start && k < 2000) begin
      @(posedge clk);
      k++;
    end
    check(eoc_n != start, req, "conversion completed", eoc_n - start, 1);
  endtask

  task automatic idle_for(input int n, input string req);
    int start;
    start = eoc_n;
    repeat (n) @(negedge clk);
    check(eoc_n == start, req, "no conversion while idle", eoc_n - start, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rcyc;
    repeat (3) @(negedge clk);
    check(status == 0, "R11", "reset status", status, 0);
    check(result == 0, "R11", "reset result", result, 0);
    check({irq, busy, eoc} == 0, "R11", "reset irq/busy/eoc", {irq, busy, eoc}, 0);
    rst_n = 1;

    // single conversion, P=2
    core_result = 8'hA5; exp_q.push_back(8'hA5);
    do_wr(0, 0, 5'd3);
    check(status == 8'h03, "R11", "status layout", status, 8'h03);
    repeat (4) @(negedge clk);
    check(busy == 1, "R2", "busy during conversion", busy, 1);
    wait_eoc("R2");
    check_range("R1", "latency P=2", eoc_cyc - (wcyc + 1), 33, 34);
    @(negedge clk);
    check(status[7] == 1, "R4", "done set", status[7], 1);
    core_result = 8'h00;
    idle_for(100, "R2");
    check(busy == 0, "R2", "busy low after single", busy, 0);
    check(status[7] == 1, "R4", "done held", status[7], 1);
    do_rd();
    check(status[7] == 0, "R4", "done cleared by read", status[7], 0);

    // done cleared by write; parking
    core_result = 8'h3C; exp_q.push_back(8'h3C);
    do_wr(0, 0, 5'd1);
    wait_eoc("R4");
    do_wr(0, 0, 5'd31);
    check(status[7] == 0, "R4", "done cleared by write", status[7], 0);
    idle_for(80, "R6");
    check(busy == 0, "R6", "parked converter idle", busy, 0);

    // divider P=8
    do_div(3'd3);
    core_result = 8'h5A; exp_q.push_back(8'h5A);
    do_wr(0, 0, 5'd2);
    wait_eoc("R7");
    check_range("R7", "latency P=8", eoc_cyc - (wcyc + 1), 129, 136);
    do_div(3'd0);

    // continuous without reads
    core_result = 8'h11; exp_q.push_back(8'h11);
    do_wr(0, 1, 5'd4);
    for (int i = 0; i < 3; i++) begin
      wait_eoc("R3");
      if (i < 2) begin
        @(negedge clk);
        core_result = 8'h20 + 8'(i);
        exp_q.push_back(8'h20 + 8'(i));
      end
    end
    check(result == 8'h21, "R3", "last overwrite", result, 8'h21);
    do_wr(0, 0, 5'd31);
    idle_for(100, "R3");

    // interrupt mode
    core_result = 8'h77; exp_q.push_back(8'h77);
    do_wr(1, 0, 5'd5);
    wait_eoc("R5");
    @(negedge clk);
    check(irq == 1, "R5", "irq raised", irq, 1);
    check(status[7] == 0, "R5", "done stays 0", status[7], 0);
    repeat (20) @(negedge clk);
    check(irq == 1, "R5", "irq level held", irq, 1);
    do_rd();
    check(irq == 0, "R5", "irq cleared by read", irq, 0);
    core_result = 8'h78; exp_q.push_back(8'h78);
    do_wr(1, 0, 5'd5);
    wait_eoc("R5");
    do_wr(0, 0, 5'd31);
    check(irq == 0, "R5", "irq cleared by write", irq, 0);

    // stop in single mode
    core_result = 8'h99;
    do_wr(0, 0, 5'd6);
    repeat (10) @(negedge clk);
    stop = 1;
    repeat (20) @(negedge clk);
    check(busy == 0, "R8", "halted under stop", busy, 0);
    stop = 0;
    idle_for(120, "R8");
    check(result == 8'h78, "R8", "result kept after abort", result, 8'h78);

    // stop in continuous mode, resume after settling
    core_result = 8'hAA; exp_q.push_back(8'hAA);
    do_wr(0, 1, 5'd7);
    repeat (10) @(negedge clk);
    stop = 1;
    repeat (10) @(negedge clk);
    stop = 0;
    rcyc = cyc;
    wait_eoc("R9");
    check_range("R9", "resume after settling", eoc_cyc - (rcyc + 1), 65, 66);
    do_wr(0, 0, 5'd31);

    // rewrite aborts
    core_result = 8'h42;
    do_wr(0, 0, 5'd8);
    repeat (12) @(negedge clk);
    core_result = 8'h43; exp_q.push_back(8'h43);
    do_wr(0, 0, 5'd8);
    check(result == 8'hAA, "R10", "result kept after rewrite", result, 8'hAA);
    wait_eoc("R10");
    check_range("R10", "latency from rewrite", eoc_cyc - (wcyc + 1), 33, 34);
    idle_for(60, "R2");
    check(exp_q.size() == 0, "R2", "all expected conversions seen", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule